// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block collects a stream of 32-bit trace words and stores them in a local on-chip memory that is used as a ring. Software programs a lower and an upper word address that bound the ring. Each accepted word lands at the write pointer, and the pointer steps forward by four bytes. When it has just written the upper-bound slot, it returns to the lower bound and sets a sticky flag, so the oldest trace is overwritten and the newest is kept.

Software uses a 32-bit register port to configure the block and to get the captured trace back. That port gives access to a control word, a fixed identification word, the two bound registers, both pointers and a data window. Each read of the data window returns the word at the read pointer and then moves the pointer forward, wrapping the same way as the write pointer. Each write to the data window stores a word there, which lets software test the memory. Trace enters over a valid/ready handshake.

Top module: `trace_ram_sink`

## Requirements
- R1: After reset, control reads 0, both pointers read 0 and `trace_ready` is low.
- R2: A read of offset 0x004 returns 0x00000910. In that value, bits [3:0] hold minor version 0, bits [7:4] hold major version 1 and bits [11:8] hold component type 0x9.
- R3: Any offset other than 0x000, 0x004, 0x010, 0x018, 0x020, 0x028 and 0x040 reads as 0. Writes to those offsets change nothing.
- R4: `trace_ready` is high only while control bit 0 (on) and bit 1 (capture) are both 1. While it is low, no word is stored and the write pointer (0x020) does not move.
- R5: Each accepted trace word is stored at the write pointer. If the pointer is not equal to the upper bound (0x018), it then advances by 4.
- R6: When a word is accepted at the upper bound, the write pointer loads the lower bound (0x010) and control bit 2 becomes 1. That bit stays 1 until a control write with bit 2 set clears it.
- R7: A read of 0x040 returns the word at the read pointer (0x028) and advances the pointer by 4. If the pointer is at the upper bound, it loads the lower bound instead.
- R8: Writes to the bound and pointer registers are ignored while control bit 1 is 1. When accepted, bits [1:0] of the written value are stored as 0.
- R9: A write to 0x040 while control bit 1 is 0 stores the word at the read pointer and advances the pointer as in R7. While bit 1 is 1, such a write is ignored.
- R10: Read data and `bus_rvalid` appear in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trace_valid | input | 1 | Trace word offered |
| trace_data | input | 32 | Trace word |
| trace_ready | output | 1 | Trace word accepted this cycle |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |

## Verification
The bench builds the block with a 16-word memory. The ring is set to the eight words from 0x10 to 0x2C, so a run of 20 trace words wraps the write pointer twice and leaves a known mix of old and new words in every slot. With a ring this small, the bench can check the write pointer and the sticky flag after every single word. It also reads back more than one full ring through the data window, which crosses the read-pointer wrap as well.

// File: rtl/trs_pkg.sv
package trs_pkg;
    localparam int REG_W  = 32;
    localparam int OFFS_W = 12;

    localparam logic [OFFS_W-1:0] OFF_CTRL  = 12'h000;
    localparam logic [OFFS_W-1:0] OFF_IMPL  = 12'h004;
    localparam logic [OFFS_W-1:0] OFF_START = 12'h010;
    localparam logic [OFFS_W-1:0] OFF_LIMIT = 12'h018;
    localparam logic [OFFS_W-1:0] OFF_WPTR  = 12'h020;
    localparam logic [OFFS_W-1:0] OFF_RPTR  = 12'h028;
    localparam logic [OFFS_W-1:0] OFF_DATA  = 12'h040;

    localparam logic [3:0] COMP_TYPE = 4'h9;
    localparam logic [3:0] VER_MAJOR = 4'h1;
    localparam logic [3:0] VER_MINOR = 4'h0;
    localparam logic [REG_W-1:0] IMPL_WORD =
        {20'h0, COMP_TYPE, VER_MAJOR, VER_MINOR};

    typedef struct packed {
        logic             on;
        logic             capture;
        logic             wrapped;
        logic [REG_W-1:0] lo_bound;
        logic [REG_W-1:0] hi_bound;
        logic [REG_W-1:0] wptr;
        logic [REG_W-1:0] rptr;
        logic [REG_W-1:0] rdata;
        logic             rsel_mem;
        logic             rvalid;
    } trs_state_t;
endpackage

// File: rtl/trs_ptr_step.sv
module trs_ptr_step
    import trs_pkg::*;
(
    input  logic [REG_W-1:0] ptr,
    input  logic [REG_W-1:0] lo_bound,
    input  logic [REG_W-1:0] hi_bound,
    output logic [REG_W-1:0] nxt,
    output logic             wrap
);
    always_comb begin
        wrap = (ptr == hi_bound);
        nxt  = wrap ? lo_bound : ptr + REG_W'(4);
    end
endmodule

// File: rtl/trs_mem.sv
module trs_mem #(
    parameter int WORDS  = 256,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        if (re) rdata <= cells[raddr];
    end
endmodule

// File: rtl/trace_ram_sink.sv
module trace_ram_sink
    import trs_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    localparam int IDX_W = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_valid,
    input  logic [REG_W-1:0]  trace_data,
    output logic              trace_ready,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [OFFS_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_rvalid
);
    trs_state_t st_d, st_q;

    logic [REG_W-1:0] wp_next, rp_next;
    logic             wp_wrap, rp_wrap;
    logic             push;
    logic             mem_we, mem_re;
    logic [IDX_W-1:0] mem_waddr;
    logic [REG_W-1:0] mem_wdata, mem_rdata;
    logic             bus_wr, bus_rd;

    trs_ptr_step u_wstep (
        .ptr(st_q.wptr), .lo_bound(st_q.lo_bound), .hi_bound(st_q.hi_bound),
        .nxt(wp_next), .wrap(wp_wrap)
    );

    trs_ptr_step u_rstep (
        .ptr(st_q.rptr), .lo_bound(st_q.lo_bound), .hi_bound(st_q.hi_bound),
        .nxt(rp_next), .wrap(rp_wrap)
    );

    trs_mem #(.WORDS(MEM_WORDS), .DATA_W(REG_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .re(mem_re), .raddr(st_q.rptr[IDX_W+1:2]), .rdata(mem_rdata)
    );

    assign trace_ready = st_q.on && st_q.capture;
    assign push        = trace_valid && trace_ready;
    assign bus_wr      = bus_req && bus_we;
    assign bus_rd      = bus_req && !bus_we;
    assign bus_rdata   = st_q.rsel_mem ? mem_rdata : st_q.rdata;
    assign bus_rvalid  = st_q.rvalid;

    always_comb begin
        st_d          = st_q;
        st_d.rvalid   = bus_rd;
        st_d.rsel_mem = 1'b0;
        st_d.rdata    = '0;
        mem_we        = 1'b0;
        mem_re        = 1'b0;
        mem_waddr     = st_q.wptr[IDX_W+1:2];
        mem_wdata     = trace_data;

        if (bus_wr) begin
            unique case (bus_addr)
                OFF_CTRL: begin
                    st_d.on      = bus_wdata[0];
                    st_d.capture = bus_wdata[1];
                    if (bus_wdata[2]) st_d.wrapped = 1'b0;
                end
                OFF_START: if (!st_q.capture) st_d.lo_bound = {bus_wdata[REG_W-1:2], 2'b00};
                OFF_LIMIT: if (!st_q.capture) st_d.hi_bound = {bus_wdata[REG_W-1:2], 2'b00};
                OFF_WPTR:  if (!st_q.capture) st_d.wptr     = {bus_wdata[REG_W-1:2], 2'b00};
                OFF_RPTR:  if (!st_q.capture) st_d.rptr     = {bus_wdata[REG_W-1:2], 2'b00};
                OFF_DATA: begin
                    if (!st_q.capture) begin
                        mem_we    = 1'b1;
                        mem_waddr = st_q.rptr[IDX_W+1:2];
                        mem_wdata = bus_wdata;
                        st_d.rptr = rp_next;
                    end
                end
                default: ;
            endcase
        end

        if (bus_rd) begin
            unique case (bus_addr)
                OFF_CTRL:  st_d.rdata = {29'h0, st_q.wrapped, st_q.capture, st_q.on};
                OFF_IMPL:  st_d.rdata = IMPL_WORD;
                OFF_START: st_d.rdata = st_q.lo_bound;
                OFF_LIMIT: st_d.rdata = st_q.hi_bound;
                OFF_WPTR:  st_d.rdata = st_q.wptr;
                OFF_RPTR:  st_d.rdata = st_q.rptr;
                OFF_DATA: begin
                    mem_re        = 1'b1;
                    st_d.rsel_mem = 1'b1;
                    st_d.rptr     = rp_next;
                end
                default: ;
            endcase
        end

        if (push) begin
            mem_we    = 1'b1;
            mem_waddr = st_q.wptr[IDX_W+1:2];
            mem_wdata = trace_data;
            st_d.wptr = wp_next;
            if (wp_wrap) st_d.wrapped = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic unused_ok;
    assign unused_ok = rp_wrap;
endmodule

// File: rtl/trs_chk.sv
module trs_chk
    import trs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              trace_valid,
    input logic              trace_ready,
    input logic              bus_req,
    input logic              bus_we,
    input logic [OFFS_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              bus_rvalid,
    input trs_state_t        st_q
);
    a_r4_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.on && st_q.capture) |-> !trace_ready);

    a_r5_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_valid && trace_ready && st_q.wptr != st_q.hi_bound)
        |=> st_q.wptr == $past(st_q.wptr) + 32'd4);

    a_r6_wptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_valid && trace_ready && st_q.wptr == st_q.hi_bound)
        |=> (st_q.wptr == $past(st_q.lo_bound)) && st_q.wrapped);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wrapped && !(bus_req && bus_we && bus_addr == OFF_CTRL && bus_wdata[2]))
        |=> st_q.wrapped);

    a_r4_wptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!trace_ready && st_q.capture) |=> $stable(st_q.wptr));

    a_r2_impl_value: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr == OFF_IMPL) |=> bus_rdata == 32'h0000_0910);

    a_r10_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);
endmodule

bind trace_ram_sink trs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .trace_valid(trace_valid), .trace_ready(trace_ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .st_q(st_q)
);

// File: tb/trace_ram_sink_tb.sv
module trace_ram_sink_tb;
    localparam int WORDS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_valid = 1'b0;
    logic [31:0] trace_data = '0;
    logic        trace_ready;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [WORDS];

    always #5 clk = ~clk;

    trace_ram_sink #(.MEM_WORDS(WORDS)) u_dut (
        .clk(clk), .rst_n(rst_n), .trace_valid(trace_valid), .trace_data(trace_data),
        .trace_ready(trace_ready), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        check("R10 rvalid", {31'h0, bus_rvalid}, 32'h1);
        d = bus_rdata;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk);
        trace_valid = 1'b1; trace_data = d;
        @(negedge clk);
        trace_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] wp;
        logic [31:0] rp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        check("R1 ready", {31'h0, trace_ready}, 32'h0);
        rd(12'h000, v); check("R1 ctrl", v, 32'h0);
        rd(12'h020, v); check("R1 wptr", v, 32'h0);
        rd(12'h028, v); check("R1 rptr", v, 32'h0);
        rd(12'h004, v); check("R2 impl", v, 32'h0000_0910);

        for (int a = 12'h008; a < 12'h040; a += 4) begin
            if (a != 12'h010 && a != 12'h018 && a != 12'h020 && a != 12'h028) begin
                wr(12'(a), 32'hFFFF_FFFF);
                rd(12'(a), v); check("R3 unused", v, 32'h0);
            end
        end
        wr(12'hFFC, 32'h1234_5678);
        rd(12'hFFC, v); check("R3 top", v, 32'h0);

        wr(12'h010, 32'h0000_0013);
        rd(12'h010, v); check("R8 low bits", v, 32'h10);
        wr(12'h018, 32'h0000_002C);
        wr(12'h020, 32'h0000_0010);
        rd(12'h018, v); check("R8 limit", v, 32'h2C);

        for (int m = 0; m < 3; m++) begin
            wr(12'h000, 32'(m));
            @(negedge clk);
            check("R4 ready off", {31'h0, trace_ready}, 32'h0);
            push(32'hBAD0_0000);
            rd(12'h020, v); check("R4 wptr hold", v, 32'h10);
        end

        wr(12'h000, 32'h3);
        @(negedge clk);
        check("R4 ready on", {31'h0, trace_ready}, 32'h1);
        wr(12'h020, 32'h28);
        rd(12'h020, v); check("R8 locked", v, 32'h10);

        wp = 32'h10;
        for (int k = 1; k <= 20; k++) begin
            model[wp[5:2]] = 32'hA500_0000 + 32'(k);
            push(32'hA500_0000 + 32'(k));
            wp = (wp == 32'h2C) ? 32'h10 : wp + 4;
            rd(12'h020, v); check("R5 R6 wptr", v, wp);
            rd(12'h000, v); check("R6 flag", v, (k >= 8) ? 32'h7 : 32'h3);
        end

        wr(12'h000, 32'h7);
        rd(12'h000, v); check("R6 clear", v, 32'h3);
        wr(12'h000, 32'h1);

        wr(12'h028, 32'h10);
        rp = 32'h10;
        for (int j = 0; j < 10; j++) begin
            rd(12'h040, v); check("R7 data", v, model[rp[5:2]]);
            rp = (rp == 32'h2C) ? 32'h10 : rp + 4;
        end
        rd(12'h028, v); check("R7 rptr", v, rp);

        wr(12'h028, 32'h10);
        for (int j = 0; j < 8; j++) wr(12'h040, 32'h5A00 + 32'(j));
        rd(12'h028, v); check("R9 rptr wrap", v, 32'h10);
        wr(12'h000, 32'h3);
        wr(12'h040, 32'hDEAD_BEEF);
        wr(12'h000, 32'h1);
        rd(12'h028, v); check("R9 locked rptr", v, 32'h10);
        for (int j = 0; j < 8; j++) begin
            rd(12'h040, v); check("R9 memtest", v, 32'h5A00 + 32'(j));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule